// File: doc/BRIEF.md
# Bit-Plane Corner-Turn Loader for a Serial Cell Array

This block moves one batch of 8-bit pixels between a wide word port and an array of bit-serial processing cells. The default configuration has 128 lanes. Each cell holds one pixel in its own 8-bit shift register. A word arriving on the input port is a bit-plane: lane i of the word carries one bit of the pixel that belongs to cell i. All cells shift that bit in together. After eight accepted words, every cell holds its whole pixel.

After loading, the block waits through a processing window whose length is a parameter. The cells are a pass-through hook, so the window only holds their contents. The block then returns the batch the same way. All cells shift out in parallel, and each group of lane bits is offered as one output word, so the host can rebuild every pixel from eight words. Both ports use a valid/ready handshake.

The control is a three-state machine:
- **LOAD** accepts input words. After the eighth accepted beat it moves to **PROCESS**, or straight to **UNLOAD** when the window length is 0.
- **PROCESS** counts the window and then moves to **UNLOAD**.
- **UNLOAD** offers output words. After the eighth accepted output beat it returns to **LOAD**.

Reset sends the machine to LOAD from any state.

Top module: `bitplane_loader`

## Requirements
- R1: A synchronous reset, held for one or more cycles, clears every cell register and the beat counter and returns the block to LOAD. In the cycle after reset is released, in_ready is 1, out_valid is 0 and load_done is 0. A partial load that is cut short by reset does not count toward the next batch.
- R2: in_ready is 1 only in LOAD. It is 0 during PROCESS and during UNLOAD.
- R3: Pixels load most significant bit first. Bit i of the k-th accepted input word (k = 0..7) is bit 7-k of the pixel in lane i.
- R4: A cell shifts only on a cycle where valid and ready of the active port are both 1. Data presented with in_valid low, or with in_valid high outside LOAD, is ignored.
- R5: load_done is a one-cycle pulse. It is high in the cycle after the eighth accepted input word, and at no other time.
- R6: The PROCESS window lasts PROC_CYCLES cycles. out_valid first rises PROC_CYCLES cycles after the load_done cycle. With PROC_CYCLES = 0, out_valid rises in the load_done cycle.
- R7: In UNLOAD, out_valid stays 1 and out_data stays stable until out_ready is 1. Bit i of the k-th accepted output word is bit 7-k of the pixel held in lane i.
- R8: After the eighth accepted output word, the block returns to LOAD: out_valid is 0 and in_ready is 1 in the next cycle.
- R9: The processing hook is pass-through. Every pixel rebuilt from the eight output words equals the pixel that was loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block accepts an input word (LOAD only) |
| in_data | input | LANES | Input bit-plane, lane i goes to cell i |
| load_done | output | 1 | One-cycle pulse after the last input beat |
| out_valid | output | 1 | Output word is valid (UNLOAD only) |
| out_ready | input | 1 | Host accepts the output word |
| out_data | output | LANES | Output bit-plane, lane i comes from cell i |

## Verification
The collision that matters here is an output handshake and a stray input word arriving in the same cycle. During UNLOAD the host may hold in_valid high with random data while it accepts output words. If the block accepted that input, it would corrupt the cells while they are shifting out. The bench drives random input words with in_valid high throughout every UNLOAD and PROCESS phase, and inserts stall cycles on both ports. It then judges the outcome by rebuilding each pixel from the eight output words and comparing it with the pixel that was loaded.

// File: rtl/bpl_pkg.sv
package bpl_pkg;
    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_PROCESS = 2'd1,
        ST_UNLOAD  = 2'd2
    } bpl_state_t;
endpackage

// File: rtl/bpl_cell.sv
// One serial processing cell: a shift register, entered at the LSB and read at the MSB.
module bpl_cell #(
    parameter int PIX_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic shift,
    input  logic din,
    output logic dout
);
    logic [PIX_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (shift) begin
            sr_q <= {sr_q[PIX_W-2:0], din};
        end
    end

    assign dout = sr_q[PIX_W-1];
endmodule

// File: rtl/bpl_ctrl.sv
// Sequencer: LOAD -> PROCESS -> UNLOAD -> LOAD.
module bpl_ctrl
    import bpl_pkg::*;
#(
    parameter int PIX_W       = 8,
    parameter int PROC_CYCLES = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load_done,
    output logic cell_shift,
    output logic load_sel
);
    localparam int BW      = (PIX_W > 1) ? $clog2(PIX_W) : 1;
    localparam int PCW     = (PROC_CYCLES > 1) ? $clog2(PROC_CYCLES) : 1;
    localparam int PC_LAST = (PROC_CYCLES > 0) ? PROC_CYCLES - 1 : 0;

    bpl_state_t state_q, state_d;
    logic [BW-1:0]  beat_q;
    logic [PCW-1:0] proc_q;
    logic           done_q;
    logic           in_fire, out_fire, last_beat, proc_end;

    assign in_fire   = in_valid && (state_q == ST_LOAD);
    assign out_fire  = out_ready && (state_q == ST_UNLOAD);
    assign last_beat = (beat_q == BW'(PIX_W - 1));
    assign proc_end  = (proc_q == PCW'(PC_LAST));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: begin
                if (in_fire && last_beat) begin
                    state_d = (PROC_CYCLES == 0) ? ST_UNLOAD : ST_PROCESS;
                end
            end
            ST_PROCESS: begin
                if (proc_end) state_d = ST_UNLOAD;
            end
            ST_UNLOAD: begin
                if (out_fire && last_beat) state_d = ST_LOAD;
            end
            default: state_d = ST_LOAD;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOAD;
        else     state_q <= state_d;
    end

    // Beat, window and done-pulse registers
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            proc_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= in_fire && last_beat;
            if (in_fire || out_fire) begin
                beat_q <= last_beat ? '0 : beat_q + 1'b1;
            end
            if (state_q == ST_PROCESS) proc_q <= proc_q + 1'b1;
            else                       proc_q <= '0;
        end
    end

    // Outputs
    always_comb begin
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        cell_shift = 1'b0;
        load_sel   = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                in_ready   = 1'b1;
                load_sel   = 1'b1;
                cell_shift = in_fire;
            end
            ST_PROCESS: begin
                cell_shift = 1'b0;
            end
            ST_UNLOAD: begin
                out_valid  = 1'b1;
                cell_shift = out_fire;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
    end

    assign load_done = done_q;
endmodule

// File: rtl/bitplane_loader.sv
module bitplane_loader #(
    parameter int LANES       = 128,
    parameter int PIX_W       = 8,
    parameter int PROC_CYCLES = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [LANES-1:0] in_data,
    output logic             load_done,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [LANES-1:0] out_data
);
    logic cell_shift, load_sel;

    bpl_ctrl #(.PIX_W(PIX_W), .PROC_CYCLES(PROC_CYCLES)) ctrl_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
        .in_ready(in_ready), .out_valid(out_valid), .load_done(load_done),
        .cell_shift(cell_shift), .load_sel(load_sel)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_in;
        assign lane_in = load_sel & in_data[g];
        bpl_cell #(.PIX_W(PIX_W)) cell_i (
            .clk(clk), .rst(rst), .shift(cell_shift),
            .din(lane_in), .dout(out_data[g])
        );
    end
endmodule

// File: rtl/bitplane_loader_chk.sv
module bitplane_loader_chk #(
    parameter int LANES = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             load_done,
    input logic             out_valid,
    input logic             out_ready,
    input logic [LANES-1:0] out_data
);
    // R1: state right after reset release
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_valid && !load_done));

    // R2: input is never ready while output is offered
    p_ready_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R5: load_done lasts one cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        load_done |=> !load_done);

    // R5: load_done follows an accepted input word
    p_done_cause_r5: assert property (@(posedge clk) disable iff (rst)
        (load_done && !$past(rst)) |-> $past(in_valid && in_ready));

    // R7: output held under back-pressure
    p_hold_word_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind bitplane_loader bitplane_loader_chk #(.LANES(LANES)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .load_done(load_done), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
);

// File: tb/bitplane_loader_tb_top.sv
`timescale 1ns/1ps
module bitplane_loader_tb_top;
    localparam int LANES = 128;
    localparam int PROC  = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             out_ready = 1'b0;
    logic [LANES-1:0] in_data = '0;
    logic             in_ready, load_done, out_valid;
    logic [LANES-1:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [7:0] pix [LANES];
    logic [7:0] got [LANES];

    always #4 clk = ~clk;

    bitplane_loader #(.LANES(LANES), .PIX_W(8), .PROC_CYCLES(PROC)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .load_done(load_done), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [LANES-1:0] plane(input int k);
        logic [LANES-1:0] w;
        for (int i = 0; i < LANES; i++) w[i] = pix[i][7-k];
        return w;
    endfunction

    function automatic logic [LANES-1:0] junk();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(in_ready && !out_valid && !load_done, "R1 reset outputs",
            {in_ready, out_valid, load_done}, 3'b100);
    endtask

    // Loads nwords of the current batch; gaps carry junk with in_valid low.
    task automatic load_words(input int nwords, input int gap_seed);
        for (int k = 0; k < nwords; k++) begin
            for (int g = 0; g < (gap_seed + k) % 3; g++) begin
                in_valid = 1'b0; in_data = junk();
                @(negedge clk);
            end
            chk(in_ready == 1'b1, "R2 ready in LOAD", in_ready, 1);
            chk(load_done == 1'b0, "R5 no early done", load_done, 0);
            in_valid = 1'b1; in_data = plane(k);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic run_batch(input int b);
        load_words(8, b);
        // Negedge after the 8th accept edge.
        chk(load_done == 1'b1, "R5 done pulse", load_done, 1);
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R2 PROCESS ready low",
            {in_ready, out_valid}, 0);
        in_valid = 1'b1; in_data = junk();   // R4: ignored outside LOAD
        for (int c = 1; c < PROC; c++) begin
            @(negedge clk); in_data = junk();
            chk(!load_done && !out_valid && !in_ready, "R6 window",
                {load_done, out_valid, in_ready}, 0);
        end
        @(negedge clk);
        chk(out_valid == 1'b1, "R6 window end", out_valid, 1);
        for (int k = 0; k < 8; k++) begin
            logic [LANES-1:0] hold;
            hold = out_data;
            for (int s = 0; s < (b * k) % 3; s++) begin
                out_ready = 1'b0; in_data = junk();
                @(negedge clk);
                chk(out_valid && out_data == hold, "R7 hold", out_data, hold);
            end
            chk(in_ready == 1'b0, "R2 UNLOAD ready low", in_ready, 0);
            chk(out_data == plane(k), "R7 word bits", out_data, plane(k));
            for (int i = 0; i < LANES; i++) got[i][7-k] = out_data[i];
            out_ready = 1'b1; in_data = junk();   // collision: output fire + stray input
            @(negedge clk);
        end
        out_ready = 1'b0; in_valid = 1'b0;
        chk(!out_valid && in_ready, "R8 back to LOAD", {out_valid, in_ready}, 2'b01);
        begin
            int bad;
            bad = -1;
            for (int i = 0; i < LANES; i++) if (got[i] != pix[i] && bad < 0) bad = i;
            chk(bad < 0, "R9 R3 R4 pixel rebuild",
                (bad < 0) ? '0 : LANES'(got[bad]), (bad < 0) ? '0 : LANES'(pix[bad]));
        end
    endtask

    initial begin
        do_reset();
        // R1: partial load then reset; the next batch needs exactly eight beats.
        for (int i = 0; i < LANES; i++) pix[i] = 8'hA5;
        load_words(3, 0);
        do_reset();
        for (int b = 0; b < 6; b++) begin
            for (int i = 0; i < LANES; i++) begin
                case (b)
                    0: pix[i] = 8'h00;
                    1: pix[i] = 8'hFF;
                    2: pix[i] = 8'(i);
                    3: pix[i] = 8'((i * 37 + 53) & 255);
                    default: pix[i] = 8'($urandom);
                endcase
            end
            run_batch(b);
        end
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule